// File: doc/BRIEF.md
# DMA Channel Transfer Controller

This block is one channel of a DMA engine. It waits for a request, raises an acknowledge and then moves data from a source address to a destination address over a simple memory-bus master port. Each move is an atomic operation: one read and then one write per beat, with one beat per operation in single-unit mode or four beats in burst mode. After every beat both addresses advance by the data size, which is 1, 2 or 4 bytes.

The request comes either from one of seven hardware lines, picked by a select field, or from a software trigger. A configuration input picks the source, the transfer count, the service mode, the data size, the unit size and whether an interrupt is wanted at terminal count.

A main sequencer has the states WAIT, LOAD and XFER. Its transitions are:
- WAIT to LOAD when a request is seen.
- LOAD to XFER unconditionally.
- XFER to WAIT after the last operation, or after one operation in single mode.
- XFER to XFER, restarting the mover, in whole mode while count remains.

A mover sub-sequencer has the states IDLE, READ and WRITE. Its transitions are:
- IDLE to READ on start.
- READ to WRITE on ready.
- WRITE to READ on ready while beats remain.
- WRITE to IDLE on ready after the last beat.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, `ack`, `irq`, `bus_rd` and `bus_wr` are all 0.
- R2: With `cfg_hw_req`=1, only `hw_req[cfg_src_sel]` starts a transfer. Other hardware lines and `sw_trigger` cause no acknowledge and no bus activity.
- R3: With `cfg_hw_req`=0, `sw_trigger` starts a transfer. All `hw_req` lines cause no acknowledge and no bus activity.
- R4: `ack` goes to 1 in the cycle after the clock edge at which a request is seen in WAIT.
- R5: Each beat reads `bus_rdata` at the current source address and then writes that same value to the current destination address. A write always follows its read.
- R6: `cfg_burst`=0 gives one beat per operation and `cfg_burst`=1 gives four. After each beat both addresses advance by the data size: `cfg_dsize` 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes.
- R7: The mover holds `bus_rd` or `bus_wr`, together with its address and write data, until `bus_ready` is 1. A read with n wait states keeps `bus_rd` high for n+1 cycles.
- R8: In whole mode (`cfg_whole`=1), one request runs `cfg_count` operations under a single `ack` high period. `ack` drops after the last operation.
- R9: In single mode, each request runs exactly one operation and `ack` drops after it. The remaining count and the addresses carry over to the next request, and a change of `cfg_count` in mid-job has no effect.
- R10: `irq` is a one-cycle pulse. It is raised after the operation that takes the count to 0, only if `cfg_irq_en`=1, and never after any other operation.
- R11: The count and the addresses are reloaded from `cfg_count`, `src_addr` and `dst_addr` at LOAD in whole mode, or in single mode when the previous count has reached 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_count | input | 20 | Number of atomic operations in a job |
| cfg_irq_en | input | 1 | Raise irq at terminal count |
| cfg_whole | input | 1 | 1: whole service mode, 0: single service mode |
| cfg_hw_req | input | 1 | 1: hardware request lines, 0: software trigger |
| cfg_src_sel | input | 3 | Index of the hardware request line |
| cfg_dsize | input | 2 | Data size code (0 byte, 1 half, 2/3 word) |
| cfg_burst | input | 1 | 1: four-beat unit, 0: single beat |
| sw_trigger | input | 1 | Software request |
| hw_req | input | 7 | Hardware request lines |
| src_addr | input | 32 | Job source start address |
| dst_addr | input | 32 | Job destination start address |
| bus_addr | output | 32 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data |
| bus_ready | input | 1 | Access completes this cycle |
| ack | output | 1 | Request acknowledge |
| irq | output | 1 | Terminal-count interrupt pulse |

## Verification
The bench first drives the unselected hardware lines and the wrong-mode trigger. A channel that decoded the select or the mode wrongly would raise `ack` or touch the bus. It then runs byte, halfword and word jobs in single-beat and burst units with wait states. An error in the address step, the beat count or the ready handshake shows up as wrong write addresses, wrong data or wrong read-strobe cycle counts. In single mode, the bench changes `cfg_count` in mid-job and checks that the job still ends at its third request with one `irq`, and that the addresses continue from request to request. A channel that reloaded on every request, or raised `irq` on every operation, would fail there. A new job is then started to confirm that reloading does happen once the count has reached zero.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        M_WAIT = 2'd0,
        M_LOAD = 2'd1,
        M_XFER = 2'd2
    } main_state_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } mover_state_t;

    // byte step for a data size code; codes 2 and 3 both mean a word
    function automatic logic [2:0] step_of(input logic [1:0] dsize);
        unique case (dsize)
            2'd0:    step_of = 3'd1;
            2'd1:    step_of = 3'd2;
            default: step_of = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_req_select.sv
module dma_req_select #(
    parameter int NUM_SRC = 7,
    localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               hw_mode,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [NUM_SRC-1:0] hw_req,
    input  logic               sw_trigger,
    output logic               req
);

    logic [NUM_SRC-1:0] hit;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
            assign hit[i] = hw_req[i] && (src_sel == SEL_W'(i));
        end
    endgenerate

    assign req = hw_mode ? (|hit) : sw_trigger;

endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int BURST_BEATS = 4,
    localparam int BEAT_W     = $clog2(BURST_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic              start,
    input  logic              burst,
    input  logic [1:0]        dsize,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              done
);

    mover_state_t      state;
    logic [ADDR_W-1:0] rptr;
    logic [ADDR_W-1:0] wptr;
    logic [DATA_W-1:0] data_q;
    logic [BEAT_W-1:0] beats_left;
    logic [ADDR_W-1:0] step;

    assign step = ADDR_W'(step_of(dsize));

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            rptr       <= '0;
            wptr       <= '0;
            data_q     <= '0;
            beats_left <= '0;
        end else begin
            if (load) begin
                rptr <= src_in;
                wptr <= dst_in;
            end
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        beats_left <= burst ? BEAT_W'(BURST_BEATS) : BEAT_W'(1);
                        state      <= S_READ;
                    end
                end
                S_READ: begin
                    if (bus_ready) begin
                        data_q <= bus_rdata;
                        state  <= S_WRITE;
                    end
                end
                S_WRITE: begin
                    if (bus_ready) begin
                        rptr       <= rptr + step;
                        wptr       <= wptr + step;
                        beats_left <= beats_left - BEAT_W'(1);
                        state      <= (beats_left == BEAT_W'(1)) ? S_IDLE : S_READ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        bus_rd    = (state == S_READ);
        bus_wr    = (state == S_WRITE);
        bus_addr  = (state == S_WRITE) ? wptr : rptr;
        bus_wdata = data_q;
        done      = (state == S_WRITE) && bus_ready && (beats_left == BEAT_W'(1));
    end

    // R7: a read waiting for ready keeps its strobe and address
    a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));

    // R7: a write waiting for ready keeps its strobe, address and data
    a_r7_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    // R5: a completed read is followed by its write
    a_r5_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_ready) |=> bus_wr);

    // R5: never both strobes together
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

endmodule

// File: rtl/dma_main_seq.sv
module dma_main_seq
    import dma_chan_pkg::*;
#(
    parameter int TC_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [TC_W-1:0] cfg_count,
    input  logic            cfg_irq_en,
    input  logic            cfg_whole,
    input  logic            mover_done,
    output logic            mover_start,
    output logic            mover_load,
    output logic            ack,
    output logic            irq
);

    main_state_t     state;
    logic [TC_W-1:0] curr_tc;
    logic            restart_q;
    logic            irq_q;
    logic            reload;

    assign reload = cfg_whole || (curr_tc == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= M_WAIT;
            curr_tc   <= '0;
            restart_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            irq_q     <= 1'b0;
            unique case (state)
                M_WAIT: begin
                    if (req) state <= M_LOAD;
                end
                M_LOAD: begin
                    if (reload) curr_tc <= cfg_count;
                    state <= M_XFER;
                end
                M_XFER: begin
                    if (mover_done) begin
                        curr_tc <= curr_tc - TC_W'(1);
                        if (curr_tc == TC_W'(1)) begin
                            irq_q <= cfg_irq_en;
                            state <= M_WAIT;
                        end else if (!cfg_whole) begin
                            state <= M_WAIT;
                        end else begin
                            restart_q <= 1'b1;
                        end
                    end
                end
                default: state <= M_WAIT;
            endcase
        end
    end

    // outputs
    always_comb begin
        ack         = (state != M_WAIT);
        mover_start = (state == M_LOAD) || restart_q;
        mover_load  = (state == M_LOAD) && reload;
        irq         = irq_q;
    end

    // R10: interrupt lasts one cycle
    a_r10_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: interrupt only with the count exhausted and the channel back in WAIT
    a_r10_irq_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (curr_tc == '0 && state == M_WAIT));

    // R4: a request seen in WAIT raises ack next cycle
    a_r4_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_WAIT && req) |=> ack);

    // R8: whole mode keeps ack while count remains
    a_r8_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_XFER && mover_done && cfg_whole && curr_tc != TC_W'(1)) |=> ack);

    // R9: single mode drops ack after one operation
    a_r9_single_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_XFER && mover_done && !cfg_whole) |=> !ack);

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int TC_W        = 20,
    parameter int NUM_SRC     = 7,
    parameter int BURST_BEATS = 4,
    localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TC_W-1:0]    cfg_count,
    input  logic               cfg_irq_en,
    input  logic               cfg_whole,
    input  logic               cfg_hw_req,
    input  logic [SEL_W-1:0]   cfg_src_sel,
    input  logic [1:0]         cfg_dsize,
    input  logic               cfg_burst,
    input  logic               sw_trigger,
    input  logic [NUM_SRC-1:0] hw_req,
    input  logic [ADDR_W-1:0]  src_addr,
    input  logic [ADDR_W-1:0]  dst_addr,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_rd,
    output logic               bus_wr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               bus_ready,
    output logic               ack,
    output logic               irq
);

    logic req;
    logic mover_start;
    logic mover_load;
    logic mover_done;

    dma_req_select #(.NUM_SRC(NUM_SRC)) u_req_select (
        .hw_mode    (cfg_hw_req),
        .src_sel    (cfg_src_sel),
        .hw_req     (hw_req),
        .sw_trigger (sw_trigger),
        .req        (req)
    );

    dma_main_seq #(.TC_W(TC_W)) u_main_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .cfg_count   (cfg_count),
        .cfg_irq_en  (cfg_irq_en),
        .cfg_whole   (cfg_whole),
        .mover_done  (mover_done),
        .mover_start (mover_start),
        .mover_load  (mover_load),
        .ack         (ack),
        .irq         (irq)
    );

    dma_mover #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .BURST_BEATS (BURST_BEATS)
    ) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (mover_load),
        .src_in    (src_addr),
        .dst_in    (dst_addr),
        .start     (mover_start),
        .burst     (cfg_burst),
        .dsize     (cfg_dsize),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .done      (mover_done)
    );

endmodule

// File: tb/dma_chan_ctrl_bench.sv
`timescale 1ns/1ps
module dma_chan_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cfg_count = '0;
    logic        cfg_irq_en = 1'b0, cfg_whole = 1'b0, cfg_hw_req = 1'b0, cfg_burst = 1'b0;
    logic [2:0]  cfg_src_sel = '0;
    logic [1:0]  cfg_dsize = '0;
    logic        sw_trigger = 1'b0;
    logic [6:0]  hw_req = '0;
    logic [31:0] src_addr = '0, dst_addr = '0;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_rd, bus_wr, bus_ready, ack, irq;

    always #5 clk = ~clk;

    dma_chan_ctrl u_dma_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_count(cfg_count), .cfg_irq_en(cfg_irq_en),
        .cfg_whole(cfg_whole), .cfg_hw_req(cfg_hw_req), .cfg_src_sel(cfg_src_sel),
        .cfg_dsize(cfg_dsize), .cfg_burst(cfg_burst), .sw_trigger(sw_trigger),
        .hw_req(hw_req), .src_addr(src_addr), .dst_addr(dst_addr),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .ack(ack), .irq(irq)
    );

    // memory model: data is a fixed function of the address, with lat wait states
    int unsigned lat = 0;
    int unsigned wcnt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) wcnt <= 0;
        else if ((bus_rd || bus_wr) && !bus_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
    end
    assign bus_ready = (bus_rd || bus_wr) && (wcnt >= lat);
    assign bus_rdata = {bus_addr[15:0], ~bus_addr[15:0]};

    function automatic logic [31:0] pattern(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // activity log sampled away from the active edge
    logic [31:0] wr_addr [0:63];
    logic [31:0] wr_data [0:63];
    int wr_n, rd_cyc, busy_cyc, ack_rises, irq_cnt;
    bit irq_long, ack_prev, irq_prev;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_wr && bus_ready && wr_n < 64) begin
                wr_addr[wr_n] = bus_addr;
                wr_data[wr_n] = bus_wdata;
                wr_n++;
            end
            if (bus_rd) rd_cyc++;
            if (bus_rd || bus_wr) busy_cyc++;
            if (ack && !ack_prev) ack_rises++;
            if (irq) irq_cnt++;
            if (irq && irq_prev) irq_long = 1'b1;
            ack_prev = ack;
            irq_prev = irq;
        end
    end

    int total = 0, fails = 0;
    bit ended = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report;
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    task automatic clear_log;
        wr_n = 0; rd_cyc = 0; busy_cyc = 0; ack_rises = 0; irq_cnt = 0; irq_long = 1'b0;
    endtask

    task automatic pulse_hw(input int i);
        @(negedge clk); hw_req[i] = 1'b1;
        @(negedge clk); hw_req[i] = 1'b0;
    endtask

    task automatic pulse_all_hw;
        @(negedge clk); hw_req = '1;
        @(negedge clk); hw_req = '0;
    endtask

    task automatic pulse_sw;
        @(negedge clk); sw_trigger = 1'b1;
        @(negedge clk); sw_trigger = 1'b0;
    endtask

    task automatic wait_idle;
        int n = 0;
        repeat (2) @(negedge clk);
        while (ack && n < 5000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_beats(input string tag, input int n, input logic [31:0] s,
                               input logic [31:0] d, input int step);
        for (int i = 0; i < n; i++) begin
            chk(wr_addr[i] == d + i*step, {tag, " write address"}, wr_addr[i], d + i*step);
            chk(wr_data[i] == pattern(s + i*step), {tag, " write data"}, wr_data[i], pattern(s + i*step));
        end
    endtask

    task automatic t_reset;
        chk(ack == 0 && irq == 0, "R1 ack/irq after reset", {ack, irq}, 0);
        chk(bus_rd == 0 && bus_wr == 0, "R1 strobes after reset", {bus_rd, bus_wr}, 0);
    endtask

    task automatic t_hw_whole_byte;
        cfg_hw_req = 1; cfg_src_sel = 3'd2; cfg_whole = 1; cfg_count = 20'd3;
        cfg_dsize = 2'd0; cfg_burst = 0; cfg_irq_en = 1; lat = 0;
        src_addr = 32'h0000_1000; dst_addr = 32'h0000_2000;
        clear_log;
        pulse_hw(5); pulse_sw; repeat (20) @(negedge clk);
        chk(ack_rises == 0, "R2 unselected line / sw trigger raised ack", ack_rises, 0);
        chk(busy_cyc == 0, "R2 unselected line / sw trigger caused bus use", busy_cyc, 0);
        pulse_hw(2);
        chk(ack == 1, "R4 ack after selected request", ack, 1);
        wait_idle;
        chk(wr_n == 3, "R8 whole-mode operation count", wr_n, 3);
        check_beats("R5 byte single", 3, 32'h0000_1000, 32'h0000_2000, 1);
        chk(ack_rises == 1, "R8 one ack period", ack_rises, 1);
        chk(irq_cnt == 1, "R10 irq at terminal count", irq_cnt, 1);
        chk(!irq_long, "R10 irq one cycle", irq_long, 0);
    endtask

    task automatic t_burst_word_wait;
        cfg_hw_req = 1; cfg_src_sel = 3'd6; cfg_whole = 1; cfg_count = 20'd2;
        cfg_dsize = 2'd2; cfg_burst = 1; cfg_irq_en = 1; lat = 2;
        src_addr = 32'h0000_4000; dst_addr = 32'h0000_8000;
        clear_log;
        pulse_hw(6); wait_idle;
        chk(wr_n == 8, "R6 word burst beats", wr_n, 8);
        check_beats("R6 word burst", 8, 32'h0000_4000, 32'h0000_8000, 4);
        chk(rd_cyc == 8*3, "R7 read strobe held through wait states", rd_cyc, 24);
        chk(irq_cnt == 1, "R10 irq after burst job", irq_cnt, 1);
    endtask

    task automatic t_burst_half_noirq;
        cfg_hw_req = 1; cfg_src_sel = 3'd0; cfg_whole = 1; cfg_count = 20'd1;
        cfg_dsize = 2'd1; cfg_burst = 1; cfg_irq_en = 0; lat = 1;
        src_addr = 32'h0000_0100; dst_addr = 32'h0000_0300;
        clear_log;
        pulse_hw(0); wait_idle;
        chk(wr_n == 4, "R6 half burst beats", wr_n, 4);
        check_beats("R6 half burst", 4, 32'h0000_0100, 32'h0000_0300, 2);
        chk(irq_cnt == 0, "R10 no irq when disabled", irq_cnt, 0);
    endtask

    task automatic t_sw_single;
        cfg_hw_req = 0; cfg_whole = 0; cfg_count = 20'd3;
        cfg_dsize = 2'd0; cfg_burst = 0; cfg_irq_en = 1; lat = 0;
        src_addr = 32'h0000_0500; dst_addr = 32'h0000_0A00;
        clear_log;
        pulse_all_hw; repeat (20) @(negedge clk);
        chk(ack_rises == 0, "R3 hw lines ignored in sw mode (ack)", ack_rises, 0);
        chk(busy_cyc == 0, "R3 hw lines ignored in sw mode (bus)", busy_cyc, 0);
        for (int k = 0; k < 3; k++) begin
            pulse_sw; wait_idle;
            if (k == 0) cfg_count = 20'd9;
            chk(wr_n == k + 1, "R9 one operation per request", wr_n, k + 1);
            chk(wr_addr[k] == 32'h0000_0A00 + k, "R9 address continues", wr_addr[k], 32'h0000_0A00 + k);
            chk(ack_rises == k + 1 && ack == 0, "R9 ack drops after each operation", ack_rises, k + 1);
            chk(irq_cnt == ((k == 2) ? 1 : 0), "R10 irq only on last single request", irq_cnt, (k == 2) ? 1 : 0);
        end
    endtask

    task automatic t_reload;
        cfg_count = 20'd2; src_addr = 32'h0000_0C00; dst_addr = 32'h0000_0E00;
        clear_log;
        pulse_sw; wait_idle;
        chk(wr_n == 1 && wr_addr[0] == 32'h0000_0E00, "R11 new job reloads destination", wr_addr[0], 32'h0000_0E00);
        chk(wr_data[0] == pattern(32'h0000_0C00), "R11 new job reloads source", wr_data[0], pattern(32'h0000_0C00));
        chk(irq_cnt == 0, "R10 no irq mid job", irq_cnt, 0);
        pulse_sw; wait_idle;
        chk(irq_cnt == 1, "R11 reloaded count of two ends job", irq_cnt, 1);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(0, "watchdog expired", cyc, 150000);
                report;
            end
        end
    end

    initial begin
        clear_log;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_hw_whole_byte;
        t_burst_word_wait;
        t_burst_half_noirq;
        t_sw_single;
        t_reload;
        report;
    end

endmodule